// File: doc/BRIEF.md
# Two-Level Password Access Controller

This block decides how much of a device's register space a host may touch. It keeps a 32-bit entry register that the host loads one byte at a time. It compares that value with two stored 32-bit passwords and holds one of three hierarchical access levels: user, level one or level two. Level two includes every right of level one, and level one includes every right of user.

For each access the surrounding memory logic presents a region code. One clock later the block answers with registered read-allow and write-allow flags. A third flag tells the data path to return all ones instead of the stored contents. The password bytes themselves are never readable, at any level. If the level-two password is all ones, protection is effectively off, because the entry register comes out of reset holding that value.

The stored passwords arrive as plain inputs from whatever holds them. The block only enforces who may change them. The nonvolatile storage and the bus protocol sit outside it.

Top module: `pw_access_ctrl`

## Requirements
- R1: The entry register is loaded one byte per clock through `ent_we`, `ent_idx` and `ent_byte`, with `ent_idx` 0 addressing bits 31:24 and `ent_idx` 3 addressing bits 7:0. A write to region code 1 (entry) is allowed at every level.
- R2: Synchronous reset sets the entry register to all ones and `level` to 0. The first clock after reset loads `level` from comparing all ones with the stored passwords.
- R3: `level` is encoded as 0 = user, 1 = level one, 2 = level two, and never shows 3. A match with `pw_hi` gives 2. Otherwise a match with `pw_lo` gives 1. Otherwise the result is 0, so equal passwords give 2.
- R4: A byte written at clock edge N lands in the entry register at edge N. `level` reflects the new entry value from edge N+1 onward, and still shows the old level between those two edges.
- R5: Changing `pw_lo` or `pw_hi` without a new entry write leaves `level` unchanged.
- R6: With `pw_hi` all ones at reset, `level` becomes 2 without any entry write.
- R7: Region code 0 (monitor values) is readable at any level and writable only at level 2. Region code 2 (customer tables) is readable and writable at level 1 or above. Region code 3 (configuration and lookup tables) is readable and writable only at level 2.
- R8: Region codes 1 (entry) and 4 (stored passwords) give `rd_ok` = 0 and `rd_ones` = 1 at every level. `rd_ones` is 0 for every other code.
- R9: A write to region code 4 is allowed only at level 2. Below that, `wr_ok` is 0, so the write is dropped.
- R10: Region codes 5 to 7 are reserved and give `rd_ok` = `wr_ok` = `rd_ones` = 0 at every level.
- R11: `rd_ok`, `wr_ok` and `rd_ones` are registered. After edge N they reflect `region` sampled at edge N and the level held at edge N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ent_we | input | 1 | Entry byte write strobe |
| ent_idx | input | 2 | Entry byte index, 0 = most significant |
| ent_byte | input | 8 | Entry byte value |
| pw_lo | input | 32 | Stored level-one password |
| pw_hi | input | 32 | Stored level-two password |
| region | input | 3 | Region code of the current access |
| level | output | 2 | Current access level |
| rd_ok | output | 1 | Read of the region is permitted |
| wr_ok | output | 1 | Write to the region is permitted |
| rd_ones | output | 1 | Read data must be replaced by all ones |

## Verification
The bench sweeps every region code at each of the three levels and derives each expected flag from the permission rules, so a swapped level threshold or a readable password region shows up as a mismatched flag.

It writes a single low-order byte into an entry that is otherwise all ones. A reversed byte index would match the wrong password, or none at all.

It changes `pw_hi` while level two is held and checks that the level stays put. It then rewrites one entry byte and checks the level exactly one edge after the entry update. A design that compares continuously, or that is off by one cycle, would drop the level early or late.

Further tests cover an all-ones `pw_hi` and an all-ones `pw_lo` out of reset, and equal stored passwords. A wrong reset value would leave the level at 0, and a wrong priority would give level 1 where 2 is due.

// File: rtl/pw_access_pkg.sv
package pw_access_pkg;
  localparam int REGION_W = 3;
  localparam int LEVEL_W  = 2;

  typedef enum logic [LEVEL_W-1:0] {
    LVL_USER = 2'd0,
    LVL_ONE  = 2'd1,
    LVL_TWO  = 2'd2
  } level_e;

  localparam logic [REGION_W-1:0] RG_MONITOR = 3'd0;
  localparam logic [REGION_W-1:0] RG_ENTRY   = 3'd1;
  localparam logic [REGION_W-1:0] RG_CUST    = 3'd2;
  localparam logic [REGION_W-1:0] RG_CONFIG  = 3'd3;
  localparam logic [REGION_W-1:0] RG_PWSTORE = 3'd4;
  localparam logic [REGION_W-1:0] RG_LAST    = RG_PWSTORE;
endpackage

// File: rtl/pw_entry_reg.sv
module pw_entry_reg #(
  parameter int PW_W   = 32,
  parameter int BYTE_W = 8,
  localparam int NB    = PW_W / BYTE_W,
  localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [PW_W-1:0]   entry_o,
  output logic              changed_o
);
  // byte lane 0 holds the most significant byte
  for (genvar g = 0; g < NB; g++) begin : g_lane
    localparam int HI = PW_W - 1 - g * BYTE_W;
    always_ff @(posedge clk) begin
      if (rst) begin
        entry_o[HI -: BYTE_W] <= '1;
      end else if (we_i && (idx_i == IDX_W'(g))) begin
        entry_o[HI -: BYTE_W] <= byte_i;
      end
    end
  end

  // request a fresh compare after reset and after every byte write
  always_ff @(posedge clk) begin
    if (rst) changed_o <= 1'b1;
    else     changed_o <= we_i;
  end

  AST_ENTRY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> $stable(entry_o)); // R4
  AST_ENTRY_FLAG: assert property (@(posedge clk) disable iff (rst)
    we_i |=> changed_o); // R4
endmodule

// File: rtl/pw_level_eval.sv
module pw_level_eval
  import pw_access_pkg::*;
#(
  parameter int PW_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               eval_i,
  input  logic [PW_W-1:0]    entry_i,
  input  logic [PW_W-1:0]    pw_lo_i,
  input  logic [PW_W-1:0]    pw_hi_i,
  output logic [LEVEL_W-1:0] level_o
);
  level_e next_lvl;
  level_e lvl_q;

  always_comb begin
    if (entry_i == pw_hi_i)      next_lvl = LVL_TWO;
    else if (entry_i == pw_lo_i) next_lvl = LVL_ONE;
    else                         next_lvl = LVL_USER;
  end

  always_ff @(posedge clk) begin
    if (rst)         lvl_q <= LVL_USER;
    else if (eval_i) lvl_q <= next_lvl;
  end

  assign level_o = lvl_q;

  AST_LVL_LEGAL: assert property (@(posedge clk) disable iff (rst)
    level_o != 2'd3); // R3
  AST_LVL_PERSIST: assert property (@(posedge clk) disable iff (rst)
    !eval_i |=> $stable(level_o)); // R5
endmodule

// File: rtl/pw_perm_map.sv
module pw_perm_map
  import pw_access_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [REGION_W-1:0] region_i,
  input  logic [LEVEL_W-1:0]  level_i,
  output logic                rd_ok_o,
  output logic                wr_ok_o,
  output logic                rd_ones_o
);
  logic at_one, at_two;
  logic rd_n, wr_n, ones_n;

  assign at_two = (level_i == LVL_TWO);
  assign at_one = at_two || (level_i == LVL_ONE);

  always_comb begin
    rd_n = 1'b0; wr_n = 1'b0; ones_n = 1'b0;
    case (region_i)
      RG_MONITOR: begin rd_n = 1'b1;   wr_n = at_two; end
      RG_ENTRY:   begin ones_n = 1'b1; wr_n = 1'b1;   end
      RG_CUST:    begin rd_n = at_one; wr_n = at_one; end
      RG_CONFIG:  begin rd_n = at_two; wr_n = at_two; end
      RG_PWSTORE: begin ones_n = 1'b1; wr_n = at_two; end
      default:    begin rd_n = 1'b0;   wr_n = 1'b0;   end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ok_o <= 1'b0; wr_ok_o <= 1'b0; rd_ones_o <= 1'b0;
    end else begin
      rd_ok_o <= rd_n; wr_ok_o <= wr_n; rd_ones_o <= ones_n;
    end
  end

  AST_PW_NO_READ: assert property (@(posedge clk) disable iff (rst)
    (region_i == RG_ENTRY || region_i == RG_PWSTORE) |=> (!rd_ok_o && rd_ones_o)); // R8
  AST_ENTRY_OPEN: assert property (@(posedge clk) disable iff (rst)
    (region_i == RG_ENTRY) |=> wr_ok_o); // R1
  AST_CUST_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (region_i == RG_CUST && level_i == LVL_USER) |=> (!rd_ok_o && !wr_ok_o)); // R7
  AST_PWSTORE_GUARD: assert property (@(posedge clk) disable iff (rst)
    (region_i == RG_PWSTORE && level_i != LVL_TWO) |=> !wr_ok_o); // R9
  AST_RESERVED_DENY: assert property (@(posedge clk) disable iff (rst)
    (region_i > RG_LAST) |=> (!rd_ok_o && !wr_ok_o && !rd_ones_o)); // R10
endmodule

// File: rtl/pw_access_ctrl.sv
module pw_access_ctrl
  import pw_access_pkg::*;
#(
  parameter int PW_W   = 32,
  parameter int BYTE_W = 8,
  localparam int NB    = PW_W / BYTE_W,
  localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ent_we,
  input  logic [IDX_W-1:0]    ent_idx,
  input  logic [BYTE_W-1:0]   ent_byte,
  input  logic [PW_W-1:0]     pw_lo,
  input  logic [PW_W-1:0]     pw_hi,
  input  logic [REGION_W-1:0] region,
  output logic [LEVEL_W-1:0]  level,
  output logic                rd_ok,
  output logic                wr_ok,
  output logic                rd_ones
);
  logic [PW_W-1:0] entry;
  logic            changed;

  pw_entry_reg #(.PW_W(PW_W), .BYTE_W(BYTE_W)) u_entry (
    .clk(clk), .rst(rst), .we_i(ent_we), .idx_i(ent_idx),
    .byte_i(ent_byte), .entry_o(entry), .changed_o(changed)
  );

  pw_level_eval #(.PW_W(PW_W)) u_level (
    .clk(clk), .rst(rst), .eval_i(changed), .entry_i(entry),
    .pw_lo_i(pw_lo), .pw_hi_i(pw_hi), .level_o(level)
  );

  pw_perm_map u_perm (
    .clk(clk), .rst(rst), .region_i(region), .level_i(level),
    .rd_ok_o(rd_ok), .wr_ok_o(wr_ok), .rd_ones_o(rd_ones)
  );
endmodule

// File: tb/pw_access_ctrl_test.sv
module pw_access_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ent_we = 1'b0;
  logic [1:0]  ent_idx = '0;
  logic [7:0]  ent_byte = '0;
  logic [31:0] pw_lo = '0;
  logic [31:0] pw_hi = '0;
  logic [2:0]  region = '0;
  logic [1:0]  level;
  logic        rd_ok, wr_ok, rd_ones;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pw_access_ctrl uut (
    .clk(clk), .rst(rst), .ent_we(ent_we), .ent_idx(ent_idx),
    .ent_byte(ent_byte), .pw_lo(pw_lo), .pw_hi(pw_hi), .region(region),
    .level(level), .rd_ok(rd_ok), .wr_ok(wr_ok), .rd_ones(rd_ones)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_rd(input int r, input int l);
    case (r)
      0: return 1;
      2: return (l >= 1) ? 1 : 0;
      3: return (l == 2) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_wr(input int r, input int l);
    case (r)
      0, 3, 4: return (l == 2) ? 1 : 0;
      1: return 1;
      2: return (l >= 1) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_ones(input int r);
    return (r == 1 || r == 4) ? 1 : 0;
  endfunction

  task automatic do_reset();
    rst = 1'b1; ent_we = 1'b0; region = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic wr_byte(input int idx, input logic [7:0] v);
    ent_we = 1'b1; ent_idx = 2'(idx); ent_byte = v;
    @(negedge clk);
    ent_we = 1'b0;
  endtask

  task automatic wr_pw(input logic [31:0] v);
    for (int i = 0; i < 4; i++) wr_byte(i, v[31 - 8*i -: 8]);
    @(negedge clk);
  endtask

  task automatic sweep(input int l);
    for (int r = 0; r < 8; r++) begin
      region = 3'(r);
      @(negedge clk);
      // R7 R8 R9 R10 R11: registered permissions per region and level
      chk($sformatf("R7/R9 wr_ok region=%0d level=%0d", r, l), int'(wr_ok), exp_wr(r, l));
      chk($sformatf("R8/R10 rd_ok region=%0d level=%0d", r, l), int'(rd_ok), exp_rd(r, l));
      chk($sformatf("R8 R11 rd_ones region=%0d", r), int'(rd_ones), exp_ones(r));
    end
    region = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    pw_lo = 32'h1234_5678; pw_hi = 32'hCAFE_0042;
    do_reset();
    chk("R2 reset level", int'(level), 0);
    sweep(0);

    wr_byte(0, 8'h12);
    @(negedge clk);
    chk("R4 partial entry level", int'(level), 0);
    wr_pw(32'h1234_5678);
    chk("R3 level one match", int'(level), 1);
    sweep(1);

    wr_pw(32'hCAFE_0042);
    chk("R3 level two match", int'(level), 2);
    sweep(2);

    pw_hi = 32'h0000_0000;
    repeat (3) @(negedge clk);
    chk("R5 level persists after stored change", int'(level), 2);
    wr_byte(3, 8'h42);
    chk("R4 level before re-evaluation edge", int'(level), 2);
    @(negedge clk);
    chk("R4 level after re-evaluation edge", int'(level), 0);

    pw_hi = 32'hFFFF_FFFF; pw_lo = 32'h0BAD_F00D;
    do_reset();
    chk("R6 all-ones high password", int'(level), 2);

    pw_lo = 32'hFFFF_FFFF; pw_hi = 32'h0102_0304;
    do_reset();
    chk("R3 all-ones low password", int'(level), 1);

    pw_lo = 32'hA5A5_A5A5; pw_hi = 32'hA5A5_A5A5;
    do_reset();
    wr_pw(32'hA5A5_A5A5);
    chk("R3 equal passwords priority", int'(level), 2);

    pw_lo = 32'hFFFF_FF5A; pw_hi = 32'h5AFF_FFFF;
    do_reset();
    chk("R2 reset level byte order case", int'(level), 0);
    wr_byte(3, 8'h5A);
    @(negedge clk);
    chk("R1 index 3 is low byte", int'(level), 1);
    do_reset();
    wr_byte(0, 8'h5A);
    @(negedge clk);
    chk("R1 index 0 is high byte", int'(level), 2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule